// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block watches a slow free-running clock and raises a request when software fails to service it in time. The clock passes through a fixed binary divider that makes a base tick. A postscaler counts those ticks, and a 4-bit select picks one of sixteen power-of-two taps on it. When the chosen tap fills, the block emits a one-clock request. If the device is asleep, the request is a wake-up. Otherwise it is a device reset.

The watchdog runs whenever the hardware enable is high. Software can switch it on through its own enable, but only when the hardware enable is low. Both counters return to zero on any of these: a reset, the watchdog being off, a service strobe, a sleep-entry strobe, a clock-failure flag, or any change in the 3-bit oscillator setting. The oscillator change is found by comparing the setting with a registered copy of its value from the previous cycle.

Top module: `wdog_postscale`

## Requirements
- R1: While `rst_n` is low, both request outputs are 0 and both counters are zero. A reset applied in the middle of a count discards that count, and the next request comes a full period after reset is released.
- R2: When `hw_en` and `sw_en` are both low, the counters are held at zero and no request is produced. Enabling again after a pause starts a full period from zero.
- R3: With PRE_W divider bits and `period_sel` = n (0..15), requests are spaced 2^(PRE_W+n) clocks apart. The select values cover ratios 1:1 through 1:32768, and the default PRE_W=7 gives a base of 128 clocks.
- R4: The watchdog runs when `hw_en` OR `sw_en` is high. `sw_en` alone runs it while `hw_en` is low, and `hw_en` high runs it whatever the value of `sw_en`.
- R5: A clear condition zeroes both counters. The clear conditions are: `clr_strobe` high, `sleep_strobe` high, `clk_fail` high, or `osc_set` differing from its value in the previous cycle. The next request comes 2^(PRE_W+n) clocks after the last cycle in which a clear condition held.
- R6: Each request is exactly one clock wide. The counters restart from zero in the same step, so requests repeat with a fixed period while the block runs undisturbed.
- R7: The route is decided by `in_sleep` in the cycle the tap fills. If `in_sleep` is 1, the request goes out on `dog_wake_req`. If it is 0, the request goes out on `dog_rst_req`. The two outputs are never high together.
- R8: Changing `period_sel` is not a clear. The new tap applies to the running count: a request fires on the first base tick at which the low n bits of the postscaler count are all ones.
- R9: A clear condition wins over a timeout in the same cycle. While a clear condition is held, no request is produced, even at the shortest period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset (covers all device resets) |
| hw_en | input | 1 | Hardware configuration enable |
| sw_en | input | 1 | Software enable, effective only when `hw_en` is low |
| period_sel | input | SEL_W | Postscaler tap select, ratio 2^n |
| clr_strobe | input | 1 | Service (clear-watchdog) strobe |
| sleep_strobe | input | 1 | Sleep-entry strobe |
| osc_set | input | OSC_W | Current oscillator frequency setting |
| clk_fail | input | 1 | Clock-failure flag |
| in_sleep | input | 1 | Device is in a sleep or power-managed mode |
| dog_rst_req | output | 1 | One-clock device-reset request |
| dog_wake_req | output | 1 | One-clock wake-up request |

## Verification
The bench builds the block with PRE_W=1, so the base tick is two clocks instead of 128. This puts the whole select range in reach, including the longest tap at n=15, which takes 65536 clocks. SEL_W and OSC_W keep their defaults. The short base period also makes it practical to aim each clear source, the in-flight select change and the clear-versus-timeout collision at exact cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Registered request outputs of the watchdog
    typedef struct packed {
        logic rst_req;
        logic wake_req;
    } dog_out_t;

    // Route taken by a timeout
    typedef enum logic {
        ROUTE_RESET = 1'b0,
        ROUTE_WAKE  = 1'b1
    } dog_route_e;

endpackage

// File: rtl/wdog_ctl.sv
module wdog_ctl #(
    parameter int OSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             sw_en,
    input  logic             clr_strobe,
    input  logic             sleep_strobe,
    input  logic             clk_fail,
    input  logic [OSC_W-1:0] osc_set,
    output logic             wipe
);

    typedef struct packed {
        logic [OSC_W-1:0] osc;
    } ctl_t;

    ctl_t st_d, st_q;
    logic running;
    logic osc_moved;

    always_comb begin
        st_d      = st_q;
        st_d.osc  = osc_set;
        running   = hw_en | sw_en;
        osc_moved = (osc_set != st_q.osc);
        wipe      = ~running | clr_strobe | sleep_strobe | clk_fail | osc_moved;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdog_div.sv
module wdog_div #(
    parameter int PRE_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    output logic tick
);

    localparam logic [PRE_W-1:0] LAST = '1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (wipe) begin
            st_d.cnt = '0;
        end else begin
            tick     = (st_q.cnt == LAST);
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdog_post.sv
module wdog_post #(
    parameter int SEL_W  = 4,
    parameter int POST_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    typedef struct packed {
        logic [POST_W-1:0] cnt;
    } post_t;

    post_t st_d, st_q;
    logic [POST_W-1:0] mask;
    logic              full;

    // Tap mask: bit g is part of the tap when g is below the select value
    for (genvar g = 0; g < POST_W; g++) begin : g_mask
        assign mask[g] = (g < int'(sel));
    end

    always_comb begin
        st_d   = st_q;
        full   = ((st_q.cnt & mask) == mask);
        expire = 1'b0;
        if (wipe) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (full) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale
    import wdog_pkg::*;
#(
    parameter int PRE_W = 7,
    parameter int SEL_W = 4,
    parameter int OSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             sw_en,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             clr_strobe,
    input  logic             sleep_strobe,
    input  logic [OSC_W-1:0] osc_set,
    input  logic             clk_fail,
    input  logic             in_sleep,
    output logic             dog_rst_req,
    output logic             dog_wake_req
);

    localparam int POST_W = (1 << SEL_W) - 1;

    logic       wipe;
    logic       tick;
    logic       expire;
    dog_route_e route;
    dog_out_t   out_d, out_q;

    wdog_ctl #(.OSC_W(OSC_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_en        (hw_en),
        .sw_en        (sw_en),
        .clr_strobe   (clr_strobe),
        .sleep_strobe (sleep_strobe),
        .clk_fail     (clk_fail),
        .osc_set      (osc_set),
        .wipe         (wipe)
    );

    wdog_div #(.PRE_W(PRE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (wipe),
        .tick  (tick)
    );

    wdog_post #(.SEL_W(SEL_W), .POST_W(POST_W)) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe   (wipe),
        .tick   (tick),
        .sel    (period_sel),
        .expire (expire)
    );

    always_comb begin
        route          = in_sleep ? ROUTE_WAKE : ROUTE_RESET;
        out_d          = '0;
        out_d.rst_req  = expire & (route == ROUTE_RESET);
        out_d.wake_req = expire & (route == ROUTE_WAKE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dog_rst_req  = out_q.rst_req;
    assign dog_wake_req = out_q.wake_req;

endmodule

// File: rtl/wdog_postscale_chk.sv
module wdog_postscale_chk (
    input logic clk,
    input logic rst_n,
    input logic hw_en,
    input logic sw_en,
    input logic clr_strobe,
    input logic sleep_strobe,
    input logic clk_fail,
    input logic in_sleep,
    input logic dog_rst_req,
    input logic dog_wake_req
);

    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dog_rst_req && dog_wake_req)); // R7

    AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        dog_wake_req |-> $past(in_sleep)); // R7

    AST_RESET_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        dog_rst_req |-> !$past(in_sleep)); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en || sw_en) |=> !(dog_rst_req || dog_wake_req)); // R2

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_strobe || sleep_strobe || clk_fail) |=> !(dog_rst_req || dog_wake_req)); // R9

    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (dog_rst_req || dog_wake_req) |=> !(dog_rst_req || dog_wake_req)); // R6

endmodule

bind wdog_postscale wdog_postscale_chk u_wdog_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_en        (hw_en),
    .sw_en        (sw_en),
    .clr_strobe   (clr_strobe),
    .sleep_strobe (sleep_strobe),
    .clk_fail     (clk_fail),
    .in_sleep     (in_sleep),
    .dog_rst_req  (dog_rst_req),
    .dog_wake_req (dog_wake_req)
);

// File: tb/wdog_postscale_bench.sv
module wdog_postscale_bench;

    localparam int     PRE_W = 1;
    localparam int     SEL_W = 4;
    localparam int     OSC_W = 3;
    localparam longint LIMIT = 190000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n        = 1'b0;
    logic             hw_en        = 1'b0;
    logic             sw_en        = 1'b0;
    logic             clr_strobe   = 1'b0;
    logic             sleep_strobe = 1'b0;
    logic             clk_fail     = 1'b0;
    logic             in_sleep     = 1'b0;
    logic [SEL_W-1:0] period_sel   = '0;
    logic [OSC_W-1:0] osc_set      = '0;
    logic             dog_rst_req;
    logic             dog_wake_req;

    int     checks = 0;
    int     fails  = 0;
    int     seen   = 0;
    longint cyc    = 0;
    bit     done   = 1'b0;

    typedef struct {
        bit     wake;
        longint at;
        string  req;
    } exp_t;

    exp_t sb[$];

    wdog_postscale #(.PRE_W(PRE_W), .SEL_W(SEL_W), .OSC_W(OSC_W)) u_wdog_postscale (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_en        (hw_en),
        .sw_en        (sw_en),
        .period_sel   (period_sel),
        .clr_strobe   (clr_strobe),
        .sleep_strobe (sleep_strobe),
        .osc_set      (osc_set),
        .clk_fail     (clk_fail),
        .in_sleep     (in_sleep),
        .dog_rst_req  (dog_rst_req),
        .dog_wake_req (dog_wake_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic longint per(int sel);
        return longint'(1) << (PRE_W + sel);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_pulse(bit wake, longint at, string req);
        exp_t e;
        e.wake = wake;
        e.at   = at;
        e.req  = req;
        sb.push_back(e);
    endtask

    task automatic drain(string req);
        wait_neg(3);
        check(sb.size() == 0, req, "outstanding expected requests", sb.size(), 0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Monitor: pop and compare each request as it appears
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && cyc > sb[0].at) begin
                check(1'b0, sb[0].req, "request missing at cycle", cyc, sb[0].at);
                void'(sb.pop_front());
            end
            if (dog_rst_req || dog_wake_req) begin
                seen++;
                if (sb.size() == 0) begin
                    check(1'b0, "R6", "unexpected request at cycle", cyc, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.at, e.req, "request cycle", cyc, e.at);
                    check(dog_wake_req == e.wake, e.req, "wake route", dog_wake_req, e.wake);
                end
            end
        end
    end

    // Watchdog on the run itself
    initial begin
        wait (cyc >= LIMIT);
        if (!done) begin
            check(1'b0, "watchdog", "run did not finish by cycle", cyc, LIMIT);
            report();
            $finish;
        end
    end

    initial begin
        longint c;
        longint c2;
        int     s0;

        // R1: reset state
        wait_neg(3);
        check(!dog_rst_req && !dog_wake_req, "R1", "outputs during reset",
              {dog_rst_req, dog_wake_req}, 0);
        rst_n = 1'b1;

        // R2: disabled produces nothing
        wait_neg(40);
        check(seen == 0, "R2", "requests while disabled", seen, 0);

        // R3 / R6: shortest period, periodic
        period_sel = 4'd0; hw_en = 1'b1; c = cyc;
        expect_pulse(1'b0, c + per(0), "R3");
        expect_pulse(1'b0, c + 2 * per(0), "R6");
        expect_pulse(1'b0, c + 3 * per(0), "R6");
        wait_neg(7);
        hw_en = 1'b0;
        drain("R6");

        // R4: software enable alone
        period_sel = 4'd3; sw_en = 1'b1; c = cyc;
        expect_pulse(1'b0, c + per(3), "R4");
        expect_pulse(1'b0, c + 2 * per(3), "R4");
        wait_neg(33);
        sw_en = 1'b0;
        drain("R4");

        // R4: hardware enable runs regardless of software enable
        hw_en = 1'b1; sw_en = 1'b0; c = cyc;
        expect_pulse(1'b0, c + per(3), "R4");
        expect_pulse(1'b0, c + 2 * per(3), "R4");
        wait_neg(33);
        hw_en = 1'b0;
        drain("R4");

        // R5: each clear source restarts the count
        hw_en = 1'b1; c = cyc;
        wait_neg(10);
        clr_strobe = 1'b1; wait_neg(1); clr_strobe = 1'b0;
        expect_pulse(1'b0, c + 11 + per(3), "R5");
        wait_neg(19);
        sleep_strobe = 1'b1; wait_neg(1); sleep_strobe = 1'b0;
        expect_pulse(1'b0, c + 31 + per(3), "R5");
        wait_neg(19);
        osc_set = 3'd5;
        expect_pulse(1'b0, c + 51 + per(3), "R5");
        wait_neg(20);
        clk_fail = 1'b1; wait_neg(3); clk_fail = 1'b0;
        expect_pulse(1'b0, c + 73 + per(3), "R5");
        wait_neg(17);
        hw_en = 1'b0;
        osc_set = 3'd0;
        drain("R5");

        // R7: route by sleep state
        period_sel = 4'd1; in_sleep = 1'b1; hw_en = 1'b1; c = cyc;
        expect_pulse(1'b1, c + per(1), "R7");
        expect_pulse(1'b1, c + 2 * per(1), "R7");
        wait_neg(8);
        in_sleep = 1'b0;
        expect_pulse(1'b0, c + 3 * per(1), "R7");
        wait_neg(5);
        hw_en = 1'b0;
        drain("R7");

        // R8: select change keeps the running count
        period_sel = 4'd4; hw_en = 1'b1; c = cyc;
        wait_neg(10);
        period_sel = 4'd2;
        expect_pulse(1'b0, c + 16, "R8");
        expect_pulse(1'b0, c + 16 + per(2), "R8");
        wait_neg(15);
        hw_en = 1'b0;
        drain("R8");

        // R9: held clear suppresses timeouts
        period_sel = 4'd0; clr_strobe = 1'b1; hw_en = 1'b1; s0 = seen; c = cyc;
        wait_neg(20);
        check(seen == s0, "R9", "requests while clear held", seen - s0, 0);
        clr_strobe = 1'b0;
        expect_pulse(1'b0, c + 20 + per(0), "R9");
        wait_neg(3);
        hw_en = 1'b0;
        drain("R9");

        // R1: reset in the middle of a count
        period_sel = 4'd3; hw_en = 1'b1;
        wait_neg(10);
        rst_n = 1'b0;
        wait_neg(2);
        check(!dog_rst_req && !dog_wake_req, "R1", "outputs in mid-run reset",
              {dog_rst_req, dog_wake_req}, 0);
        rst_n = 1'b1; c2 = cyc;
        expect_pulse(1'b0, c2 + per(3), "R1");
        wait_neg(17);
        hw_en = 1'b0;
        drain("R1");

        // R2: pause and re-enable restarts from zero
        hw_en = 1'b1;
        wait_neg(10);
        hw_en = 1'b0;
        wait_neg(4);
        hw_en = 1'b1; c2 = cyc;
        expect_pulse(1'b0, c2 + per(3), "R2");
        wait_neg(17);
        hw_en = 1'b0;
        drain("R2");

        // R3: longest tap
        period_sel = 4'd15; hw_en = 1'b1; c = cyc;
        expect_pulse(1'b0, c + per(15), "R3");
        wait_neg(int'(per(15)) + 1);
        hw_en = 1'b0;
        drain("R3");

        done = 1'b1;
        report();
        $finish;
    end

endmodule